// File: doc/BRIEF.md
# Fault Restart Backoff Timer

This block manages automatic re-enabling of a small set of output channels while a degraded fallback mode is in force. In that mode each channel's enable follows its own input pin. If the channel's fault flag comes up (over-load, short circuit or over-temperature), the enable drops in the same cycle. While the input stays high the channel is then re-armed after a waiting period. That period doubles from one stage to the next, and each stage holds for eight attempts. A final stage at eight times the base period repeats for as long as the condition lasts.

Time is counted in pulses of a one-cycle `tick` strobe, normally one per millisecond. The base period and the low-time threshold are parameters, so short values can be used in simulation. If a channel's input stays low for more than `LOW_TICKS` ticks, its schedule returns to the first stage. Leaving fallback mode clears every channel's schedule. Each channel exposes its stage (0 to 3) and the attempt number within that stage.

Top module: `restart_backoff`

## Requirements
- R1: While `fallbackOn` is low, every `chanEn` bit is 0, and one clock later every channel's stage and retry fields read 0. After reset all outputs read 0.
- R2: With fallback active and no fault, `chanEn[i]` rises one clock after `chanIn[i]` rises and falls in the same cycle that `chanIn[i]` falls.
- R3: `chanEn[i]` is 0 in every cycle in which `chanFault[i]` is 1.
- R4: After a fault switches a channel off, with the input held high, a restart occurs on the tick that completes `BASE_DELAY << s` ticks, where s is the stage in effect. Stages 0, 1 and 2 each last eight restarts. Each restart adds one to the retry field (bits [3i+2:3i] of `retryIdx`), and the eighth restart of a stage moves the stage field (bits [2i+1:2i] of `stageIdx`) up by one with retry 0.
- R5: Stage 3 waits `8*BASE_DELAY` ticks per restart without limit. Its retry field wraps modulo 8, and the stage stays at 3.
- R6: If the fault flag is clear at a restart, the channel stays enabled and its stage and retry fields hold their values.
- R7: An input low lasting no more than `LOW_TICKS` ticks keeps the channel's stage and retry. The enable is 0 during the low.
- R8: An input low lasting more than `LOW_TICKS` ticks sets that channel's stage and retry to 0. The next fault run then starts again at `BASE_DELAY`.
- R9: Each channel has its own schedule: faults and lows on one channel leave the other channels' enables and fields unchanged.
- R10: While fallback is active, stage and retry fields change only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fallbackOn | input | 1 | Fallback mode active |
| tick | input | 1 | One-cycle timebase pulse |
| chanIn | input | NUM_CH | Per-channel input pins |
| chanFault | input | NUM_CH | Per-channel fault flags |
| chanEn | output | NUM_CH | Per-channel output enables |
| stageIdx | output | 2*NUM_CH | Per-channel backoff stage, channel i at [2i+1:2i] |
| retryIdx | output | 3*NUM_CH | Per-channel retry within stage, channel i at [3i+2:3i] |

## Verification
Turn-off by a fault, by a low input or by leaving the mode is combinational, so the bench samples `chanEn` one time step after it changes the input. A rising input is registered once and is checked at the next falling clock edge. A restart lands on the clock edge that carries the completing tick. A scoreboard queues the expected stage, retry, elapsed tick count and enable for each restart. A monitor compares each of these at the falling edge after the fields change, counting ticks on the same rising edges the design uses. Faults are raised only in a cycle where neither the previous edge nor the next edge carries a tick, so the count is exact.

// File: rtl/restart_pkg.sv
package restart_pkg;
  localparam int STAGE_W = 2;
  localparam int RETRY_W = 3;
  localparam logic [STAGE_W-1:0] LAST_STAGE = 2'd3;

  typedef enum logic [1:0] {CH_IDLE, CH_ON, CH_WAIT} chState_t;

  // control -> datapath
  typedef struct packed {
    logic clrSched;
    logic advSched;
    logic clrDelay;
    logic incDelay;
    logic clrLow;
    logic incLow;
  } schedStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic delayDone;
    logic lowExpired;
  } schedStatus_t;
endpackage

// File: rtl/restart_dp.sv
module restart_dp
  import restart_pkg::*;
#(
  parameter int BASE_DELAY = 10,
  parameter int LOW_TICKS  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  schedStrobe_t       strobe,
  output schedStatus_t       status,
  output logic [STAGE_W-1:0] stage,
  output logic [RETRY_W-1:0] retry
);
  localparam int DLY_W = $clog2(BASE_DELAY * 8);
  localparam int LOW_W = $clog2(LOW_TICKS + 1);

  logic [DLY_W-1:0] delayCnt;
  logic [LOW_W-1:0] lowCnt;
  logic [DLY_W:0]   curDelay;

  assign curDelay = (DLY_W+1)'(BASE_DELAY) << stage;
  assign status.delayDone  = ({1'b0, delayCnt} == (curDelay - 1'b1));
  assign status.lowExpired = (lowCnt == LOW_W'(LOW_TICKS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage <= '0;
      retry <= '0;
    end else if (strobe.clrSched) begin
      stage <= '0;
      retry <= '0;
    end else if (strobe.advSched) begin
      retry <= retry + 3'd1;
      if (retry == 3'd7 && stage != LAST_STAGE) stage <= stage + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrDelay) delayCnt <= '0;
    else if (strobe.incDelay)     delayCnt <= delayCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrLow) lowCnt <= '0;
    else if (strobe.incLow)     lowCnt <= lowCnt + 1'b1;
  end
endmodule

// File: rtl/restart_ctrl.sv
module restart_ctrl
  import restart_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fallbackOn,
  input  logic         tick,
  input  logic         pinIn,
  input  logic         fault,
  input  schedStatus_t status,
  output schedStrobe_t strobe,
  output logic         en
);
  chState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (!fallbackOn) begin
      stateNxt        = CH_IDLE;
      strobe.clrSched = 1'b1;
      strobe.clrDelay = 1'b1;
      strobe.clrLow   = 1'b1;
    end else if (!pinIn) begin
      stateNxt        = CH_IDLE;
      strobe.clrDelay = 1'b1;
      if (tick) begin
        if (status.lowExpired) strobe.clrSched = 1'b1;
        else                   strobe.incLow   = 1'b1;
      end
    end else begin
      strobe.clrLow = 1'b1;
      unique case (state)
        CH_IDLE: stateNxt = CH_ON;
        CH_ON: if (fault) begin
          stateNxt        = CH_WAIT;
          strobe.clrDelay = 1'b1;
        end
        CH_WAIT: if (tick) begin
          if (status.delayDone) begin
            stateNxt        = CH_ON;
            strobe.advSched = 1'b1;
            strobe.clrDelay = 1'b1;
          end else begin
            strobe.incDelay = 1'b1;
          end
        end
        default: stateNxt = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CH_IDLE;
    else       state <= stateNxt;
  end

  // turn-off paths are combinational; turn-on waits for the registered state
  assign en = (state == CH_ON) && pinIn && fallbackOn && !fault;
endmodule

// File: rtl/restart_backoff.sv
module restart_backoff
  import restart_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int BASE_DELAY = 10,
  parameter int LOW_TICKS  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fallbackOn,
  input  logic                    tick,
  input  logic [NUM_CH-1:0]       chanIn,
  input  logic [NUM_CH-1:0]       chanFault,
  output logic [NUM_CH-1:0]       chanEn,
  output logic [2*NUM_CH-1:0]     stageIdx,
  output logic [3*NUM_CH-1:0]     retryIdx
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    schedStrobe_t       strobe;
    schedStatus_t       status;
    logic [STAGE_W-1:0] stage;
    logic [RETRY_W-1:0] retry;

    restart_ctrl uCtrl (
      .clk       (clk),
      .rstN      (rstN),
      .fallbackOn(fallbackOn),
      .tick      (tick),
      .pinIn     (chanIn[i]),
      .fault     (chanFault[i]),
      .status    (status),
      .strobe    (strobe),
      .en        (chanEn[i])
    );

    restart_dp #(.BASE_DELAY(BASE_DELAY), .LOW_TICKS(LOW_TICKS)) uDp (
      .clk   (clk),
      .rstN  (rstN),
      .strobe(strobe),
      .status(status),
      .stage (stage),
      .retry (retry)
    );

    assign stageIdx[2*i +: 2] = stage;
    assign retryIdx[3*i +: 3] = retry;
  end
endmodule

// File: rtl/restart_backoff_chk.sv
module restart_backoff_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                fallbackOn,
  input logic                tick,
  input logic [NUM_CH-1:0]   chanIn,
  input logic [NUM_CH-1:0]   chanFault,
  input logic [NUM_CH-1:0]   chanEn,
  input logic [2*NUM_CH-1:0] stageIdx,
  input logic [3*NUM_CH-1:0] retryIdx
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r3_fault_blocks_en: assert property (@(posedge clk) disable iff (!rstN)
      chanFault[i] |-> !chanEn[i]);

    a_r2_en_needs_pin_and_mode: assert property (@(posedge clk) disable iff (!rstN)
      chanEn[i] |-> (chanIn[i] && fallbackOn));

    a_r1_mode_off_clears: assert property (@(posedge clk) disable iff (!rstN)
      !fallbackOn |=> (stageIdx[2*i +: 2] == 2'd0 && retryIdx[3*i +: 3] == 3'd0));

    a_r10_moves_on_tick_only: assert property (@(posedge clk) disable iff (!rstN)
      (fallbackOn && !tick) |=> ($stable(stageIdx[2*i +: 2]) && $stable(retryIdx[3*i +: 3])));

    a_r4_stage_no_drop_while_high: assert property (@(posedge clk) disable iff (!rstN)
      (fallbackOn && chanIn[i]) |=> (!fallbackOn || stageIdx[2*i +: 2] >= $past(stageIdx[2*i +: 2])));
  end
endmodule

bind restart_backoff restart_backoff_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .fallbackOn(fallbackOn),
  .tick      (tick),
  .chanIn    (chanIn),
  .chanFault (chanFault),
  .chanEn    (chanEn),
  .stageIdx  (stageIdx),
  .retryIdx  (retryIdx)
);

// File: tb/tb_restart_backoff.sv
module tb_restart_backoff;
  localparam int BASE = 2;
  localparam int LOWT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fallbackOn = 1'b0;
  logic [1:0] chanIn = '0;
  logic [1:0] chanFault = '0;
  logic [1:0] phase = '0;
  logic       tick;
  logic [1:0] chanEn;
  logic [3:0] stageIdx;
  logic [5:0] retryIdx;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) phase <= phase + 2'd1;
  assign tick = (phase == 2'd3);

  restart_backoff #(.NUM_CH(2), .BASE_DELAY(BASE), .LOW_TICKS(LOWT)) dut (
    .clk(clk), .rstN(rstN), .fallbackOn(fallbackOn), .tick(tick),
    .chanIn(chanIn), .chanFault(chanFault), .chanEn(chanEn),
    .stageIdx(stageIdx), .retryIdx(retryIdx)
  );

  typedef struct {
    int    stage;
    int    retry;
    int    ticks;
    bit    en;
    string req;
  } item_t;

  item_t q[$];
  int    nChk = 0, nFail = 0, mChk = 0, mFail = 0;
  int    tickTotal = 0;
  bit    monEn = 1'b0;
  bit    wdFail = 1'b0;

  always @(posedge clk) if (tick) tickTotal <= tickTotal + 1;

  // expected schedule for restart number k (1-based) of an uninterrupted fault run
  function automatic int stageAfter(int k);
    return (k < 24) ? k / 8 : 3;
  endfunction
  function automatic int delayFor(int k);
    return BASE << stageAfter(k - 1);
  endfunction

  task automatic pushRestart(int k, bit enExp);
    item_t it;
    it.stage = stageAfter(k);
    it.retry = k % 8;
    it.ticks = delayFor(k);
    it.en    = enExp;
    it.req   = enExp ? "R6" : ((stageAfter(k - 1) == 3) ? "R5" : "R4");
    q.push_back(it);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic alignPhase(logic [1:0] p);
    do @(negedge clk); while (phase != p);
  endtask

  task automatic waitDrain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             nChk + mChk + (wdFail ? 1 : 0), nFail + mFail + (wdFail ? 1 : 0));
  endtask

  // monitor: compares each restart of channel 0 against the queue
  initial begin
    logic [1:0] prevS, curS;
    logic [2:0] prevR, curR;
    int mark;
    item_t it;
    prevS = '0; prevR = '0; mark = 0;
    forever begin
      @(negedge clk);
      curS = stageIdx[1:0];
      curR = retryIdx[2:0];
      if (monEn && (curS != prevS || curR != prevR)) begin
        mChk++;
        if (q.size() == 0) begin
          mFail++;
          $display("FAIL R4 unexpected restart actual=%0d/%0d expected=none", curS, curR);
        end else begin
          it = q.pop_front();
          if (curS != it.stage || curR != it.retry || (tickTotal - mark) != it.ticks
              || chanEn[0] != it.en) begin
            mFail++;
            $display("FAIL %s stage/retry/ticks/en actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                     it.req, curS, curR, tickTotal - mark, chanEn[0],
                     it.stage, it.retry, it.ticks, it.en);
          end
        end
        mark = tickTotal;
      end else if (!monEn) begin
        mark = tickTotal;
      end
      prevS = curS;
      prevR = curR;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    wdFail = 1'b1;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(chanEn == 2'b00 && stageIdx == '0 && retryIdx == '0, "R1 reset", chanEn, 0);
    rstN = 1'b1;
    chanIn = 2'b11;
    repeat (5) @(negedge clk);
    chk(chanEn == 2'b00, "R1 mode off keeps enables low", chanEn, 0);

    // R2: rise one clock late, fall at once
    fallbackOn = 1'b1;
    #1 chk(chanEn == 2'b00, "R2 not yet on", chanEn, 0);
    @(negedge clk);
    chk(chanEn == 2'b11, "R2 follows input high", chanEn, 3);
    chanIn[0] = 1'b0;
    #1 chk(chanEn == 2'b10, "R2 drops with input", chanEn, 2);
    @(negedge clk);
    chanIn[0] = 1'b1;
    @(negedge clk);
    chk(chanEn[0] == 1'b1, "R2 back on", chanEn[0], 1);

    // R3/R4/R5: fault held high through all stages
    alignPhase(2'd1);
    monEn = 1'b1;
    chanFault[0] = 1'b1;
    for (int k = 1; k <= 30; k++) pushRestart(k, 1'b0);
    #1 chk(chanEn[0] == 1'b0, "R3 fault off same cycle", chanEn[0], 0);
    chk(chanEn[1] == 1'b1, "R9 other channel on", chanEn[1], 1);
    waitDrain();

    // R6: fault gone at restart
    repeat (2) @(negedge clk);
    pushRestart(31, 1'b1);
    chanFault[0] = 1'b0;
    waitDrain();
    repeat (40) @(negedge clk);
    chk(chanEn[0] == 1'b1, "R6 stays enabled", chanEn[0], 1);
    chk(stageIdx[1:0] == 2'd3 && retryIdx[2:0] == 3'd7, "R6 count held", retryIdx[2:0], 7);
    chk(stageIdx[3:2] == 2'd0 && retryIdx[5:3] == 3'd0 && chanEn[1], "R9 channel 1 untouched",
        retryIdx[5:3], 0);
    monEn = 1'b0;

    // R7: short low (exactly LOWT ticks)
    alignPhase(2'd0);
    chanIn[0] = 1'b0;
    #1 chk(chanEn[0] == 1'b0, "R7 off while low", chanEn[0], 0);
    repeat (8) @(negedge clk);
    chk(stageIdx[1:0] == 2'd3 && retryIdx[2:0] == 3'd7, "R7 kept during short low",
        retryIdx[2:0], 7);
    chanIn[0] = 1'b1;
    repeat (12) @(negedge clk);
    chk(stageIdx[1:0] == 2'd3 && retryIdx[2:0] == 3'd7, "R7 kept after short low",
        retryIdx[2:0], 7);

    // R8: long low resets schedule, next run restarts at base delay
    alignPhase(2'd0);
    chanIn[0] = 1'b0;
    repeat (16) @(negedge clk);
    chk(stageIdx[1:0] == 2'd0 && retryIdx[2:0] == 3'd0, "R8 cleared by long low",
        {stageIdx[1:0], retryIdx[2:0]}, 0);
    chk(chanEn[1] == 1'b1 && retryIdx[5:3] == 3'd0, "R9 channel 1 unaffected", chanEn[1], 1);
    chanIn[0] = 1'b1;
    alignPhase(2'd1);
    monEn = 1'b1;
    chanFault[0] = 1'b1;
    pushRestart(1, 1'b0);
    pushRestart(2, 1'b0);
    waitDrain();
    @(negedge clk);
    monEn = 1'b0;
    chk(retryIdx[2:0] == 3'd2, "R8 fresh schedule", retryIdx[2:0], 2);

    // R1: leaving fallback clears everything
    fallbackOn = 1'b0;
    #1 chk(chanEn == 2'b00, "R1 mode exit drops enables", chanEn, 0);
    @(negedge clk);
    chk(stageIdx == '0 && retryIdx == '0, "R1 mode exit clears schedule", retryIdx, 0);

    report();
    $finish;
  end
endmodule